// File: doc/BRIEF.md
# Dual-Channel Decimating Capture Controller

This block records two 8-bit sample streams that share one sample clock into an external synchronous SRAM, and later hands the recorded data to a slow host over a four-bit data path. A decimation ratio N picks which samples are stored: one sample out of every N is kept, so a record of fixed depth covers N times as much time. The two channels taken at the same instant are stored together in one 16-bit memory word.

The block works in two separate phases. After an arm command it fills the buffer at the sample rate, writing one word per kept sample at consecutive addresses, and stops when the last address has been written. The buffer then waits until the host asks for it. It is then sent out one nibble at a time. Each nibble is held until the host acknowledges it with a four-phase handshake. A busy output covers the whole span from arm until the last nibble has been taken.

Top module: `dual_capture_ctrl`

## Requirements
- R1: After reset, `busy`, `sram_we` and `host_valid` are all 0.
- R2: A high `arm` sampled while idle starts a capture; `busy` is 1 from the following cycle on. `busy` rises only in the cycle after a cycle with `arm` high.
- R3: Counting capture cycles from k = 0 (the first clock edge after the one that accepted `arm`), the sample of cycle k is kept when k mod N = N-1, where N is `div_n`. The value 0 acts as N = 1. `div_n` is held stable during a capture.
- R4: A stored word is packed as {channel B, channel A}, with channel A in bits 7:0 and channel B in bits 15:8.
- R5: `sram_we` is high for exactly one cycle per kept sample, in the cycle after that sample's edge, with `sram_wdata` holding that sample. The write addresses run 0, 1, ... DEPTH-1 with DEPTH = 2^ADDR_W. After DEPTH writes no further write occurs.
- R6: After the buffer is full, `busy` stays 1 and `host_valid` stays 0 until a high `host_req` is sampled.
- R7: During readout each word, in address order, is sent as four nibbles, bits 3:0 first and bits 15:12 last. `host_nib` is valid and stable while `host_valid` is 1. `host_valid` drops in the cycle after `host_ack` is seen high, and the next nibble is offered only after `host_ack` is seen low.
- R8: `arm` is ignored while `busy` is 1, whether capture, full or readout. It does not restart the capture, cause writes, or disturb the readout.
- R9: Once `host_ack` is seen low after the final nibble, `busy` drops in the next cycle and a new arm is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample and system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| adc_a | input | 8 | Channel A sample |
| adc_b | input | 8 | Channel B sample |
| div_n | input | DIV_W | Decimation ratio N (0 treated as 1) |
| arm | input | 1 | Start a capture when idle |
| host_req | input | 1 | Host request to begin readout of a full buffer |
| host_ack | input | 1 | Host acknowledge of the current nibble |
| sram_addr | output | ADDR_W | SRAM word address (write in capture, read in readout) |
| sram_wdata | output | 16 | SRAM write data |
| sram_we | output | 1 | SRAM write enable |
| sram_rdata | input | 16 | SRAM read data, valid one cycle after the address |
| host_nib | output | 4 | Nibble offered to the host |
| host_valid | output | 1 | Nibble on `host_nib` is valid |
| busy | output | 1 | High from arm until readout completes |

## Verification
A divider counter that is off by one shows up as the first write enable arriving a cycle early or late. A wrong packing or lane order shows in the very first word read back. Either is visible within N cycles of the arm. An address counter that skips, or a full condition that comes at the wrong count, shows as a write at an unexpected address, or as the wrong count of writes before writing stops. A control state that ignores or mishandles arm, request or acknowledge shows as a busy level that is wrong, or as nibbles that repeat, go missing or change while offered. This is seen within one handshake.

// File: rtl/capture_pkg.sv
package capture_pkg;
    typedef enum logic [1:0] {
        CAP_IDLE    = 2'd0,
        CAP_RUN     = 2'd1,
        CAP_FULL    = 2'd2,
        CAP_READOUT = 2'd3
    } cap_state_e;

    typedef enum logic [2:0] {
        TX_OFF   = 3'd0,
        TX_ADDR  = 3'd1,
        TX_FETCH = 3'd2,
        TX_SHOW  = 3'd3,
        TX_REL   = 3'd4
    } tx_phase_e;
endpackage

// File: rtl/cap_decimator.sv
module cap_decimator #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_n,
    output logic             keep
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } dec_reg_t;

    dec_reg_t d, q;
    logic [DIV_W-1:0] limit;

    always_comb begin
        limit = (div_n == '0) ? '0 : div_n - 1'b1;
        keep  = run && (q.cnt == limit);
        d     = q;
        if (!run)
            d.cnt = '0;
        else if (keep)
            d.cnt = '0;
        else
            d.cnt = q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/cap_nibble_tx.sv
module cap_nibble_tx
    import capture_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [15:0]       rdata,
    input  logic              ack,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [3:0]        nib,
    output logic              valid,
    output logic              done
);
    localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

    typedef struct packed {
        tx_phase_e         phase;
        logic [ADDR_W-1:0] addr;
        logic [1:0]        idx;
        logic [15:0]       word;
    } tx_reg_t;

    tx_reg_t d, q;

    always_comb begin
        d    = q;
        done = 1'b0;
        case (q.phase)
            TX_OFF: begin
                if (start) begin
                    d.phase = TX_ADDR;
                    d.addr  = '0;
                    d.idx   = '0;
                end
            end
            TX_ADDR:  d.phase = TX_FETCH;
            TX_FETCH: begin
                d.word  = rdata;
                d.phase = TX_SHOW;
            end
            TX_SHOW: begin
                if (ack) d.phase = TX_REL;
            end
            TX_REL: begin
                if (!ack) begin
                    if (q.idx == 2'd3) begin
                        d.idx = '0;
                        if (q.addr == LAST) begin
                            d.phase = TX_OFF;
                            done    = 1'b1;
                        end else begin
                            d.addr  = q.addr + 1'b1;
                            d.phase = TX_ADDR;
                        end
                    end else begin
                        d.idx   = q.idx + 1'b1;
                        d.phase = TX_SHOW;
                    end
                end
            end
            default: d.phase = TX_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.phase <= TX_OFF;
        end else begin
            q <= d;
        end
    end

    assign rd_addr = q.addr;
    assign valid   = (q.phase == TX_SHOW);
    assign nib     = q.word[{q.idx, 2'b00} +: 4];
endmodule

// File: rtl/dual_capture_ctrl.sv
module dual_capture_ctrl
    import capture_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DIV_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        adc_a,
    input  logic [7:0]        adc_b,
    input  logic [DIV_W-1:0]  div_n,
    input  logic              arm,
    input  logic              host_req,
    input  logic              host_ack,
    output logic [ADDR_W-1:0] sram_addr,
    output logic [15:0]       sram_wdata,
    output logic              sram_we,
    input  logic [15:0]       sram_rdata,
    output logic [3:0]        host_nib,
    output logic              host_valid,
    output logic              busy
);
    localparam logic [ADDR_W-1:0] LAST_IDX = {ADDR_W{1'b1}};

    typedef struct packed {
        cap_state_e        state;
        logic [ADDR_W-1:0] wr_idx;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [15:0]       wdata;
    } ctl_reg_t;

    ctl_reg_t d, q;
    logic keep;
    logic tx_start, tx_done;
    logic [ADDR_W-1:0] rd_addr;

    cap_decimator #(.DIV_W(DIV_W)) i_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (q.state == CAP_RUN),
        .div_n (div_n),
        .keep  (keep)
    );

    assign tx_start = (q.state == CAP_FULL) && host_req;

    cap_nibble_tx #(.ADDR_W(ADDR_W)) i_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (tx_start),
        .rdata   (sram_rdata),
        .ack     (host_ack),
        .rd_addr (rd_addr),
        .nib     (host_nib),
        .valid   (host_valid),
        .done    (tx_done)
    );

    always_comb begin
        d    = q;
        d.we = 1'b0;
        case (q.state)
            CAP_IDLE: begin
                if (arm) begin
                    d.state  = CAP_RUN;
                    d.wr_idx = '0;
                end
            end
            CAP_RUN: begin
                if (keep) begin
                    d.we     = 1'b1;
                    d.addr   = q.wr_idx;
                    d.wdata  = {adc_b, adc_a};
                    d.wr_idx = q.wr_idx + 1'b1;
                    if (q.wr_idx == LAST_IDX) d.state = CAP_FULL;
                end
            end
            CAP_FULL: begin
                if (host_req) d.state = CAP_READOUT;
            end
            CAP_READOUT: begin
                if (tx_done) d.state = CAP_IDLE;
            end
            default: d.state = CAP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= CAP_IDLE;
        end else begin
            q <= d;
        end
    end

    assign sram_addr  = (q.state == CAP_READOUT) ? rd_addr : q.addr;
    assign sram_wdata = q.wdata;
    assign sram_we    = q.we;
    assign busy       = (q.state != CAP_IDLE);
endmodule

// File: rtl/cap_ctrl_chk.sv
module cap_ctrl_chk #(
    parameter int ADDR_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              arm,
    input logic              host_ack,
    input logic              sram_we,
    input logic [ADDR_W-1:0] sram_addr,
    input logic              busy,
    input logic              host_valid,
    input logic [3:0]        host_nib
);
    logic              have_wr;
    logic [ADDR_W-1:0] last_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            have_wr <= 1'b0;
            last_wr <= '0;
        end else if (!busy) begin
            have_wr <= 1'b0;
        end else if (sram_we) begin
            have_wr <= 1'b1;
            last_wr <= sram_addr;
        end
    end

    // R5
    addr_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_we && have_wr) |-> (sram_addr == last_wr + 1'b1));

    // R5
    first_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_we && !have_wr) |-> (sram_addr == '0));

    // R5
    we_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sram_we |-> busy);

    // R2
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(arm));

    // R7
    nib_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && !host_ack) |=> (host_valid && $stable(host_nib)));

    // R7
    nib_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && host_ack) |=> !host_valid);

    // R7
    valid_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_valid |-> busy);
endmodule

bind dual_capture_ctrl cap_ctrl_chk #(.ADDR_W(ADDR_W)) i_cap_ctrl_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm        (arm),
    .host_ack   (host_ack),
    .sram_we    (sram_we),
    .sram_addr  (sram_addr),
    .busy       (busy),
    .host_valid (host_valid),
    .host_nib   (host_nib)
);

// File: tb/test_dual_capture_ctrl.sv
`timescale 1ns/1ps
module test_dual_capture_ctrl;
    localparam int AW    = 4;
    localparam int DW    = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    adc_a = '0, adc_b = '0;
    logic [DW-1:0] div_n = '0;
    logic          arm = 1'b0, host_req = 1'b0, host_ack = 1'b0;
    logic [AW-1:0] sram_addr;
    logic [15:0]   sram_wdata, sram_rdata;
    logic          sram_we;
    logic [3:0]    host_nib;
    logic          host_valid, busy;

    always #2.5 clk = ~clk;

    dual_capture_ctrl #(.ADDR_W(AW), .DIV_W(DW)) i_dual_capture_ctrl (
        .clk(clk), .rst_n(rst_n), .adc_a(adc_a), .adc_b(adc_b), .div_n(div_n),
        .arm(arm), .host_req(host_req), .host_ack(host_ack),
        .sram_addr(sram_addr), .sram_wdata(sram_wdata), .sram_we(sram_we),
        .sram_rdata(sram_rdata), .host_nib(host_nib), .host_valid(host_valid),
        .busy(busy)
    );

    // synchronous SRAM model
    logic [15:0] mem [DEPTH];
    always @(posedge clk) begin
        if (sram_we) mem[sram_addr] <= sram_wdata;
        sram_rdata <= mem[sram_addr];
    end

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] pat(input int v);
        logic [7:0] a, b;
        a = v[7:0];
        b = 8'(v * 5 + 17);
        return {b, a};
    endfunction

    // edge counter, stimulus and write monitor
    int          ecnt = 0;
    bit          cap_on = 0;
    int          e0 = 0;
    int          neff = 1;
    int          widx = 0;
    int          we_err = 0;
    int          dat_err = 0;
    logic [15:0] expmem [DEPTH];

    always @(negedge clk) begin
        if (cap_on) begin
            int  k;
            bit  exp_we;
            k = ecnt - e0 - 1;
            exp_we = (k >= 0) && ((k % neff) == neff - 1) && (widx < DEPTH);
            if (sram_we !== exp_we) we_err++;
            if (sram_we) begin
                if (widx < DEPTH) begin
                    if (sram_addr !== AW'(widx)) dat_err++;
                    if (sram_wdata !== pat(ecnt)) dat_err++;
                    expmem[widx] = pat(ecnt);
                end
                widx++;
            end
        end
        ecnt++;
        {adc_b, adc_a} = pat(ecnt);
    end

    task automatic start_capture(input int n);
        @(negedge clk); #1;
        div_n  = DW'(n);
        neff   = (n == 0) ? 1 : n;
        widx   = 0;
        we_err = 0;
        dat_err = 0;
        arm    = 1'b1;
        e0     = ecnt;
        cap_on = 1;
        @(negedge clk); #1;
        arm = 1'b0;
        chk(busy === 1'b1, "R2", "busy after arm", busy, 1);
    endtask

    task automatic pulse_arm();
        @(negedge clk); #1; arm = 1'b1;
        @(negedge clk); #1; arm = 1'b0;
    endtask

    task automatic wait_full(input bool_ign_arm);
        int guard = 0;
        while (widx < DEPTH && guard < 5000) begin
            @(negedge clk);
            guard++;
            if (bool_ign_arm && guard == 20) begin
                #1; arm = 1'b1;
                @(negedge clk); #1; arm = 1'b0;
            end
        end
        #1;
        // linger in the full state; an ignored arm must not restart writes
        if (bool_ign_arm) pulse_arm();
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); #1;
            if (host_valid !== 1'b0 || busy !== 1'b1) we_err++;
        end
    endtask

    task automatic readout(input string tag, input bit arm_mid);
        bit ok = 1;
        int bad_w = -1;
        logic [15:0] badv = '0;
        @(negedge clk); #1; host_req = 1'b1;
        @(negedge clk); #1; host_req = 1'b0;
        for (int w = 0; w < DEPTH; w++) begin
            logic [15:0] got;
            got = '0;
            for (int n = 0; n < 4; n++) begin
                int g = 0;
                while (host_valid !== 1'b1 && g < 100) begin
                    @(negedge clk); #1; g++;
                end
                got[n*4 +: 4] = host_nib;
                host_ack = 1'b1;
                if (arm_mid && w == 3 && n == 1) arm = 1'b1;
                @(negedge clk); #1;
                arm = 1'b0;
                g = 0;
                while (host_valid !== 1'b0 && g < 100) begin
                    @(negedge clk); #1; g++;
                end
                host_ack = 1'b0;
                @(negedge clk); #1;
            end
            if (got !== expmem[w] && ok) begin
                ok = 0; bad_w = w; badv = got;
            end
        end
        chk(ok, "R7", {tag, " readout words, nibble order"},
            int'(badv), (bad_w < 0) ? 0 : int'(expmem[bad_w]));
        chk(busy === 1'b0, "R9", {tag, " busy low after last nibble"}, busy, 0);
    endtask

    task automatic run_case(input int n, input bit ign, input string tag);
        start_capture(n);
        wait_full(ign);
        chk(we_err == 0, "R3", {tag, " write timing / decimation"}, we_err, 0);
        chk(widx == DEPTH, "R5", {tag, " number of writes"}, widx, DEPTH);
        chk(dat_err == 0, "R4", {tag, " packed data and addresses"}, dat_err, 0);
        chk(host_valid === 1'b0 && busy === 1'b1, "R6", {tag, " full waits for request"},
            {host_valid, busy}, 1);
        if (ign)
            chk(we_err == 0, "R8", {tag, " arm ignored in capture and full"}, we_err, 0);
        readout(tag, ign);
        cap_on = 0;
    endtask

    initial begin
        #1;
        chk(busy === 1'b0, "R1", "busy at reset", busy, 0);
        chk(sram_we === 1'b0, "R1", "we at reset", sram_we, 0);
        chk(host_valid === 1'b0, "R1", "valid at reset", host_valid, 0);
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(busy === 1'b0 && sram_we === 1'b0, "R1", "idle after reset",
            {busy, sram_we}, 0);
        run_case(1, 0, "N=1");
        run_case(2, 0, "N=2");
        run_case(3, 0, "N=3");
        run_case(7, 1, "N=7 with arm while busy");
        run_case(0, 0, "N=0 as 1");
        run_case(5, 1, "N=5 rearm");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #200000;
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule